// File: doc/BRIEF.md
# Split Virtqueue Descriptor Chain Walker

This block serves one split-layout virtqueue on the device side. From a queue page number and a queue size, it derives three ring base addresses: the descriptor table, the ring the driver publishes buffers on, and the ring the device returns them on. The block also holds the device's private index into the published ring.

Software or a device engine issues one of three operations. A fetch pops the next published head and walks its descriptor chain. A peek walks the same chain but does not consume the head. A skip consumes a head without reading any descriptor. All reads go through a simple request/response memory port that returns 64-bit words.

Every descriptor visited is emitted as a segment carrying an address, a length and a direction. A device-writable descriptor becomes an "in" segment and a device-readable one becomes an "out" segment. At the end of each operation the block reports the head index and the number of in and out segments. A chain that is longer than the configured maximum, such as one linked into a loop, is cut off and sets a sticky error flag.

Top module: `vq_chain_walker`

## Requirements
- R1: The descriptor base is `cfg_pfn << PAGE_SHIFT`. The published-ring base is the descriptor base plus 16 × `cfg_qsize`. The returned-ring base is the published-ring base plus 4 + 2 × `cfg_qsize`, rounded up to a multiple of 2^PAGE_SHIFT.
- R2: Every operation first reads the 16-bit driver index at published base + 2 (the low 16 bits of `mem_rdata`). If it equals `next_avail`, the queue is empty: the block returns `done_ok`=0 with both counts 0, emits no segment and leaves `next_avail` unchanged.
- R3: On a non-empty fetch or peek, the head is read at published base + 4 + 2 × (`next_avail` mod `cfg_qsize`), taken from `mem_rdata[15:0]`, and reported on `done_head` with `done_ok`=1.
- R4: Descriptor i is read as two words. The first word, at descriptor base + 16 × (i mod `cfg_qsize`), is the buffer address. The second word, 8 bytes higher, holds the length in bits [31:0], the flags in [47:32] and the next index in [63:48]. Flag bit 0 is the chain-continue bit and flag bit 1 is the device-writable bit.
- R5: Each descriptor produces one `seg_valid` pulse carrying its address and length. `seg_in` is 1 when the device-writable bit is set. The walk follows the next index while the chain-continue bit is set. The operation ends with `done_in_cnt` and `done_out_cnt` equal to the number of in and out segments.
- R6: `op_code` 0 (fetch) adds 1 to `next_avail` when the queue is not empty. Codes 1 and 3 (peek) leave it unchanged while still walking the chain.
- R7: `op_code` 2 (skip) adds 1 to `next_avail` and returns `done_ok`=1 with zero counts when the queue is not empty. It reads no descriptor and emits no segment.
- R8: When a descriptor with the chain-continue bit set brings the segment total to MAX_CHAIN, the walk stops after that segment and `loop_err` is set. `loop_err` stays set until reset. A chain of exactly MAX_CHAIN descriptors whose last descriptor has no chain-continue bit does not set it.
- R9: `mem_req` stays high with `mem_addr` stable from the cycle it rises until the cycle `mem_rvalid` answers it.
- R10: After reset, `op_ready` is 1, `next_avail` is 0 and `loop_err`, `seg_valid`, `done_valid` and `mem_req` are 0. A `cfg_load` pulse while idle clears `next_avail` and blocks operation acceptance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pfn | input | PFN_W | Queue page number |
| cfg_qsize | input | 16 | Number of ring entries |
| cfg_load | input | 1 | Queue (re)configured, clears the private index |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 fetch, 1/3 peek, 2 skip |
| op_ready | output | 1 | Idle and accepting an operation |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 64 | Read data, starting at the addressed byte |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| seg_valid | output | 1 | Segment pulse |
| seg_in | output | 1 | Segment is device-writable |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment length |
| done_valid | output | 1 | Operation finished pulse |
| done_ok | output | 1 | Queue was non-empty |
| done_head | output | 16 | Head descriptor index |
| done_in_cnt | output | CNT_W | Number of in segments |
| done_out_cnt | output | CNT_W | Number of out segments |
| loop_err | output | 1 | Sticky chain-length guard hit |
| desc_base | output | ADDR_W | Descriptor table base |
| avail_base | output | ADDR_W | Published ring base |
| used_base | output | ADDR_W | Returned ring base |
| next_avail | output | 16 | Device's next published index |

## Verification
The memory-port hold property relies on two conditions on the environment. `mem_rvalid` is raised only while a request is outstanding, and `cfg_pfn` and `cfg_qsize` stay fixed while an operation is in flight, because the request address is derived from them. The index-step property relies on `cfg_load` being the only source of a non-incrementing change. `cfg_qsize` is assumed to be non-zero. The stimulus meets these conditions as follows. Its memory model answers each request exactly once, after a random wait of 0 to 2 cycles. Configuration changes are made only while the block reports `op_ready`. Queue sizes of 8 and 5 are used, so that the modulo reduction is exercised with both a power-of-two size and a size that is not one.

// File: rtl/vq_chain_walker.sv
module vq_chain_walker #(
  parameter int ADDR_W     = 64,
  parameter int PFN_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int MAX_CHAIN  = 1024,
  localparam int CNT_W     = $clog2(MAX_CHAIN + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PFN_W-1:0]  cfg_pfn,
  input  logic [15:0]       cfg_qsize,
  input  logic              cfg_load,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  output logic              op_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_rvalid,
  output logic              seg_valid,
  output logic              seg_in,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len,
  output logic              done_valid,
  output logic              done_ok,
  output logic [15:0]       done_head,
  output logic [CNT_W-1:0]  done_in_cnt,
  output logic [CNT_W-1:0]  done_out_cnt,
  output logic              loop_err,
  output logic [ADDR_W-1:0] desc_base,
  output logic [ADDR_W-1:0] avail_base,
  output logic [ADDR_W-1:0] used_base,
  output logic [15:0]       next_avail
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);
  localparam logic [1:0] OP_FETCH = 2'd0;
  localparam logic [1:0] OP_SKIP  = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_IDX, S_HEAD, S_D0, S_D1} st_t;
  st_t st;

  logic [1:0]       op_q;
  logic [15:0]      cur, qdiv, slot_avail, slot_desc;
  logic [CNT_W-1:0] in_c, out_c;
  logic [CNT_W:0]   tot_nxt;
  logic [ADDR_W-1:0] avail_end, desc_slot_addr;

  assign desc_base  = ADDR_W'(cfg_pfn) << PAGE_SHIFT;
  assign avail_base = desc_base + (ADDR_W'(cfg_qsize) << 4);
  assign avail_end  = avail_base + ADDR_W'(4) + (ADDR_W'(cfg_qsize) << 1);
  assign used_base  = (avail_end + PAGE_MASK) & ~PAGE_MASK;

  assign qdiv       = (cfg_qsize == 16'd0) ? 16'd1 : cfg_qsize;
  assign slot_avail = next_avail % qdiv;
  assign slot_desc  = cur % qdiv;
  assign desc_slot_addr = desc_base + (ADDR_W'(slot_desc) << 4);

  assign op_ready     = (st == S_IDLE) && !cfg_load;
  assign mem_req      = (st != S_IDLE);
  assign done_in_cnt  = in_c;
  assign done_out_cnt = out_c;
  assign tot_nxt      = {1'b0, in_c} + {1'b0, out_c} + 1'b1;

  always_comb begin
    case (st)
      S_IDX:   mem_addr = avail_base + ADDR_W'(2);
      S_HEAD:  mem_addr = avail_base + ADDR_W'(4) + (ADDR_W'(slot_avail) << 1);
      S_D0:    mem_addr = desc_slot_addr;
      S_D1:    mem_addr = desc_slot_addr + ADDR_W'(8);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_q       <= OP_FETCH;
      cur        <= '0;
      in_c       <= '0;
      out_c      <= '0;
      next_avail <= '0;
      loop_err   <= 1'b0;
      seg_valid  <= 1'b0;
      seg_in     <= 1'b0;
      seg_addr   <= '0;
      seg_len    <= '0;
      done_valid <= 1'b0;
      done_ok    <= 1'b0;
      done_head  <= '0;
    end else begin
      seg_valid  <= 1'b0;
      done_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cfg_load) begin
            next_avail <= '0;
          end else if (op_valid) begin
            op_q      <= op_code;
            in_c      <= '0;
            out_c     <= '0;
            done_head <= '0;
            st        <= S_IDX;
          end
        end
        S_IDX: if (mem_rvalid) begin
          if (mem_rdata[15:0] == next_avail) begin
            done_valid <= 1'b1;
            done_ok    <= 1'b0;
            st         <= S_IDLE;
          end else if (op_q == OP_SKIP) begin
            next_avail <= next_avail + 16'd1;
            done_valid <= 1'b1;
            done_ok    <= 1'b1;
            st         <= S_IDLE;
          end else begin
            st <= S_HEAD;
          end
        end
        S_HEAD: if (mem_rvalid) begin
          cur       <= mem_rdata[15:0];
          done_head <= mem_rdata[15:0];
          if (op_q == OP_FETCH) next_avail <= next_avail + 16'd1;
          st <= S_D0;
        end
        S_D0: if (mem_rvalid) begin
          seg_addr <= mem_rdata;
          st       <= S_D1;
        end
        S_D1: if (mem_rvalid) begin
          seg_len   <= mem_rdata[31:0];
          seg_in    <= mem_rdata[33];
          seg_valid <= 1'b1;
          if (mem_rdata[33]) in_c  <= in_c + 1'b1;
          else               out_c <= out_c + 1'b1;
          if (mem_rdata[32] && tot_nxt < (CNT_W+1)'(MAX_CHAIN)) begin
            cur <= mem_rdata[63:48];
            st  <= S_D0;
          end else begin
            if (mem_rdata[32]) loop_err <= 1'b1;
            done_valid <= 1'b1;
            done_ok    <= 1'b1;
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vq_chain_walker_chk.sv
module vq_chain_walker_chk #(
  parameter int ADDR_W    = 64,
  parameter int MAX_CHAIN = 1024,
  parameter int CNT_W     = 11
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       next_avail,
  input logic              loop_err,
  input logic              done_valid,
  input logic              done_ok,
  input logic [CNT_W-1:0]  done_in_cnt,
  input logic [CNT_W-1:0]  done_out_cnt
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  p_loop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_err |=> loop_err);

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ({1'b0, done_in_cnt} + {1'b0, done_out_cnt}) <= (CNT_W+1)'(MAX_CHAIN));

  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(next_avail) && !$past(cfg_load) |-> next_avail == $past(next_avail) + 16'd1);

  p_empty_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ok |-> done_in_cnt == '0 && done_out_cnt == '0);
endmodule

bind vq_chain_walker vq_chain_walker_chk #(
  .ADDR_W(ADDR_W), .MAX_CHAIN(MAX_CHAIN), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid), .mem_addr(mem_addr), .next_avail(next_avail),
  .loop_err(loop_err), .done_valid(done_valid), .done_ok(done_ok),
  .done_in_cnt(done_in_cnt), .done_out_cnt(done_out_cnt)
);

// File: tb/vq_chain_walker_tb.sv
`timescale 1ns/1ps
module vq_chain_walker_tb_top;
  localparam int MAXC  = 6;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_pfn = '0;
  logic [15:0] cfg_qsize = 16'd8;
  logic cfg_load = 1'b0, op_valid = 1'b0;
  logic [1:0] op_code = '0;
  logic op_ready, mem_req, mem_rvalid = 1'b0;
  logic [63:0] mem_addr, mem_rdata = '0;
  logic seg_valid, seg_in, done_valid, done_ok, loop_err;
  logic [63:0] seg_addr;
  logic [31:0] seg_len;
  logic [15:0] done_head, next_avail;
  logic [CNT_W-1:0] done_in_cnt, done_out_cnt;
  logic [63:0] desc_base, avail_base, used_base;

  always #2.5 clk = ~clk;

  vq_chain_walker #(.MAX_CHAIN(MAXC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pfn(cfg_pfn), .cfg_qsize(cfg_qsize),
    .cfg_load(cfg_load), .op_valid(op_valid), .op_code(op_code),
    .op_ready(op_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .seg_valid(seg_valid),
    .seg_in(seg_in), .seg_addr(seg_addr), .seg_len(seg_len),
    .done_valid(done_valid), .done_ok(done_ok), .done_head(done_head),
    .done_in_cnt(done_in_cnt), .done_out_cnt(done_out_cnt), .loop_err(loop_err),
    .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base),
    .next_avail(next_avail));

  int checks = 0, fails = 0;
  int qs = 8;
  logic [63:0] daddr [16];
  logic [31:0] dlen  [16];
  logic [15:0] dflg  [16];
  logic [15:0] dnxt  [16];
  logic [15:0] aring [16];
  logic [15:0] aidx = 0;
  logic [15:0] exp_na = 0;
  bit exp_loop = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] b_desc();  return {32'd0, cfg_pfn} << 12; endfunction
  function automatic logic [63:0] b_avail(); return b_desc() + 64'(16 * qs); endfunction
  function automatic logic [63:0] b_used();
    logic [63:0] e = b_avail() + 64'(4 + 2 * qs);
    return (e + 64'hfff) & ~64'hfff;
  endfunction

  task automatic mem_read(input logic [63:0] a, output logic [63:0] d);
    logic [63:0] ab = b_avail(), db = b_desc();
    d = 64'hdead_beef_dead_beef;
    if (a == ab + 2) d = {48'd0, aidx};
    else if (a >= ab + 4 && a < ab + 4 + 64'(2 * qs) && a[0] == 1'b0) d = {48'd0, aring[(a - ab - 4) >> 1]};
    else if (a >= db && a < ab && a[2:0] == 3'd0) begin
      if (a[3] == 1'b0) d = daddr[(a - db) >> 4];
      else d = {dnxt[(a - db) >> 4], dflg[(a - db) >> 4], dlen[(a - db) >> 4]};
    end else chk("R4", "read address outside the rings", a, 64'h0);
  endtask

  bit pending = 0;
  int wcnt = 0;
  logic [63:0] held;
  always @(negedge clk) begin
    if (!rst_n) begin mem_rvalid = 0; pending = 0; end
    else if (mem_rvalid) begin mem_rvalid = 0; pending = 0; end
    else if (mem_req) begin
      if (!pending) begin pending = 1; held = mem_addr; wcnt = $urandom % 3; end
      else if (mem_addr !== held) chk("R9", "address moved while pending", mem_addr, held);
      if (wcnt == 0) begin mem_read(mem_addr, mem_rdata); mem_rvalid = 1; end
      else wcnt--;
    end
  end

  int ng = 0;
  bit g_in [32];
  logic [63:0] g_addr [32];
  logic [31:0] g_len [32];
  bit d_seen = 0, d_ok;
  logic [15:0] d_head;
  int d_in, d_out;
  always @(negedge clk) if (rst_n) begin
    if (seg_valid) begin
      if (ng < 32) begin g_in[ng] = seg_in; g_addr[ng] = seg_addr; g_len[ng] = seg_len; end
      ng++;
    end
    if (done_valid) begin
      d_seen = 1; d_ok = done_ok; d_head = done_head;
      d_in = int'(done_in_cnt); d_out = int'(done_out_cnt);
    end
  end

  task automatic run_op(input logic [1:0] code);
    ng = 0; d_seen = 0;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1; op_code = code;
    @(negedge clk);
    op_valid = 0;
    while (!d_seen) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic post(input logic [15:0] h);
    aring[aidx % qs] = h;
    aidx++;
  endtask

  task automatic check_walk(input string req, input logic [15:0] head);
    int n = 0, ni = 0, no = 0;
    logic [15:0] cur = head;
    bit lp = 0;
    chk(req, "done_ok", d_ok, 1);
    chk(req, "done_head", d_head, head);
    forever begin
      int s = cur % qs;
      bit w = dflg[s][1];
      if (n < ng) begin
        chk(req, "seg_in", g_in[n], w);
        chk(req, "seg_addr", g_addr[n], daddr[s]);
        chk(req, "seg_len", g_len[n], dlen[s]);
      end
      if (w) ni++; else no++;
      n++;
      if (!dflg[s][0]) break;
      if (n >= MAXC) begin lp = 1; break; end
      cur = dnxt[s];
    end
    exp_loop |= lp;
    chk(req, "segment count", ng, n);
    chk(req, "done_in_cnt", d_in, ni);
    chk(req, "done_out_cnt", d_out, no);
    chk("R8", "loop_err", loop_err, exp_loop);
    chk(req, "next_avail", next_avail, exp_na);
  endtask

  task automatic mk_chain(output logic [15:0] h);
    int len = 1 + $urandom % 4;
    int s = $urandom % qs;
    for (int k = 0; k < len; k++) begin
      int sl = (s + 3 * k) % qs;
      daddr[sl] = {$urandom, $urandom};
      dlen[sl]  = $urandom;
      dflg[sl]  = 16'($urandom & 32'hfffc) | ((k < len - 1) ? 16'd1 : 16'd0) | (($urandom % 2) ? 16'd2 : 16'd0);
      dnxt[sl]  = 16'((s + 3 * (k + 1)) % qs + qs * ($urandom % 3));
    end
    h = 16'(s + qs * ($urandom % 3));
  endtask

  task automatic configure(input logic [31:0] pfn, input int q);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    cfg_pfn = pfn; cfg_qsize = 16'(q); qs = q; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0; aidx = 0; exp_na = 0;
    chk("R10", "next_avail after cfg_load", next_avail, 0);
    chk("R1", "desc_base", desc_base, b_desc());
    chk("R1", "avail_base", avail_base, b_avail());
    chk("R1", "used_base", used_base, b_used());
  endtask

  task automatic random_round(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] h;
      mk_chain(h);
      post(h);
      if ($urandom % 3 == 0) begin
        run_op(($urandom % 2) ? 2'd1 : 2'd3);
        check_walk("R6", h);
      end
      run_op(2'd0);
      exp_na++;
      check_walk("R5", h);
    end
  endtask

  initial begin
    logic [15:0] h;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin daddr[i] = 0; dlen[i] = 0; dflg[i] = 0; dnxt[i] = 0; aring[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "op_ready", op_ready, 1);
    chk("R10", "next_avail", next_avail, 0);
    chk("R10", "loop_err", loop_err, 0);
    chk("R10", "seg_valid", seg_valid, 0);
    chk("R10", "done_valid", done_valid, 0);
    chk("R10", "mem_req", mem_req, 0);

    configure(32'h12345, 8);
    chk("R1", "used_base directed", used_base, 64'h12346000);

    run_op(2'd0);
    chk("R2", "empty fetch done_ok", d_ok, 0);
    chk("R2", "empty fetch segments", ng, 0);
    chk("R2", "empty fetch next_avail", next_avail, 0);
    run_op(2'd2);
    chk("R7", "empty skip done_ok", d_ok, 0);
    chk("R7", "empty skip next_avail", next_avail, 0);

    daddr[3] = 64'h1111_2222_3333_4444; dlen[3] = 32'd1500; dflg[3] = 16'd0; dnxt[3] = 16'd0;
    post(16'd11);
    run_op(2'd1);
    check_walk("R3", 16'd11);
    run_op(2'd0);
    exp_na++;
    check_walk("R4", 16'd11);

    post(16'd3);
    run_op(2'd2);
    exp_na++;
    chk("R7", "skip done_ok", d_ok, 1);
    chk("R7", "skip segments", ng, 0);
    chk("R7", "skip counts", d_in + d_out, 0);
    chk("R7", "skip next_avail", next_avail, exp_na);

    for (int k = 0; k < 6; k++) begin
      daddr[k] = 64'(k * 4096); dlen[k] = 32'(100 + k);
      dflg[k] = ((k < 5) ? 16'd1 : 16'd0) | ((k % 2) ? 16'd2 : 16'd0);
      dnxt[k] = 16'(k + 1);
    end
    post(16'd0);
    run_op(2'd0);
    exp_na++;
    check_walk("R8", 16'd0);

    dflg[5] = 16'd3; dnxt[5] = 16'd6;
    daddr[6] = 64'h77; dlen[6] = 32'd7; dflg[6] = 16'd0;
    post(16'd0);
    run_op(2'd0);
    exp_na++;
    check_walk("R8", 16'd0);
    chk("R8", "loop_err raised", loop_err, 1);

    random_round(20);
    chk("R8", "loop_err still set", loop_err, 1);

    configure(32'h0abcd, 5);
    random_round(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule